// File: doc/BRIEF.md
# Locality Ownership Arbiter

The arbiter decides which of five localities (0 to 4) owns a shared host register interface. Each locality sees its own copy of an 8-bit access register. The locality is taken from a field of the access address. A locality can ask for ownership, give it up, or take it by force (a seize) from a lower-numbered owner. An owner that loses ownership to a seize keeps a mark that reports this. Reads return a computed view: a locality sees whether it owns the interface, whether its own request is pending, whether any other locality is waiting, and whether it was seized.

A command engine sits next to the arbiter. When a command is running (`exec_busy_i`), a handover is not made at once. The arbiter pulses `cancel_o`, remembers the pending handover, and completes it on `cmd_done_i`. The engine can also ask for the owner to abort its own command (`cmd_abort_i`). When that abort ends, `ready_o` reports that the locality has returned to the ready state. Every real change of owner raises a one-cycle `loc_changed_o`.

Top module: `loc_own_arb`

## Requirements
- R1: After reset no locality owns the interface (`owner_valid_o`=0), and every locality 0 to 4 reads 0x80: bit 7 is a valid flag that is always 1.
- R2: The locality number is `acc_addr_i[14:12]`. Writes from locality 4 are ignored. Localities 5 to 7 read 0x00 and ignore writes.
- R3: A write with bit 1 (request) from a non-owner makes that locality the owner at once if no locality owns the interface. Otherwise it sets that locality's request flag, which reads back in bit 1.
- R4: A non-owner that writes bit 5 (active) clears only its own request flag.
- R5: An owner that writes bit 5 gives up ownership. The highest-numbered locality with a request becomes the next owner. If none is waiting, no locality owns the interface.
- R6: A write with bit 3 (seize) ignores bits 1 and 5 of the same write. A seize is accepted only when there is no owner or the writer is numerically above the owner. It is refused if the writer already has a seize pending or a higher locality has one. Accepting a seize cancels the seizes of lower localities, and the writer becomes the owner.
- R7: On a handover caused by a seize, the old owner gains the been-seized flag (bit 4). On a normal handover, the old owner's request flag is cleared.
- R8: A read shows bit 5 set only for the owner. Bit 2 is set when any other locality has a request pending. Bit 3 always reads 0.
- R9: A write with bit 4 set clears the writer's been-seized flag.
- R10: `loc_changed_o` is high for exactly one cycle, in the same cycle in which `owner_o` takes a new value, and only when the owner really changes.
- R11: If `exec_busy_i` is high when a handover is requested, `cancel_o` pulses and the owner stays the same until `cmd_done_i`. The handover is then completed.
- R12: `cmd_abort_i` aborts the owner's command. When the abort ends (at once if not busy, otherwise on `cmd_done_i`), `ready_o` pulses with `ready_loc_o` equal to the owner, and the owner does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 16 | Access address; bits 14:12 select the locality |
| acc_wdata_i | input | 8 | Write data for the access register |
| acc_rdata_o | output | 8 | Read view of the addressed locality's access register (combinational) |
| exec_busy_i | input | 1 | A command is executing |
| cmd_done_i | input | 1 | The executing command has finished or was cancelled |
| cmd_abort_i | input | 1 | Abort request for the owner's own command |
| cancel_o | output | 1 | Pulse: asks the engine to cancel the running command |
| loc_changed_o | output | 1 | Pulse: the owner changed |
| ready_o | output | 1 | Pulse: a self-abort ended and the locality is ready |
| ready_loc_o | output | 3 | Locality that `ready_o` refers to |
| owner_o | output | 3 | Current owner (7 when there is none) |
| owner_valid_o | output | 1 | A locality owns the interface |

## Verification
The hardest case to reach is a chain of seizes while a command is executing. One locality's seize must be deferred and then replaced by a higher locality's seize. A lower seize must then be refused while the higher one is still waiting. The bench holds `exec_busy_i` high, issues seizes from localities 1, 2 and 1 again, and checks that `cancel_o` pulses only for the accepted seizes. It then releases `cmd_done_i` and checks that locality 2 becomes the owner and that the old owner reads back its been-seized flag.

// File: rtl/loc_own_pkg.sv
package loc_own_pkg;
  // access register bit positions (host-visible)
  localparam int unsigned B_REQ    = 1;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_SEIZE  = 3;
  localparam int unsigned B_SEIZED = 4;
  localparam int unsigned B_ACT    = 5;
  localparam int unsigned B_VALID  = 7;
endpackage

// File: rtl/lcl_prio_pick.sv
module lcl_prio_pick #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  // highest set index wins; idx is all-ones when nothing is set
  always_comb begin
    found_o = 1'b0;
    idx_o   = '1;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/lcl_read_view.sv
module lcl_read_view
  import loc_own_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic [LOC_W-1:0]   loc_i,
  input  logic [LOC_W-1:0]   owner_i,
  input  logic [NUM_LOC-1:0] req_i,
  input  logic [NUM_LOC-1:0] seized_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (loc_i < LOC_W'(NUM_LOC)) begin
      rdata_o[B_VALID]  = 1'b1;
      rdata_o[B_ACT]    = (owner_i == loc_i);
      rdata_o[B_SEIZED] = seized_i[loc_i];
      rdata_o[B_REQ]    = req_i[loc_i];
      for (int i = 0; i < NUM_LOC; i++) begin
        if (LOC_W'(i) != loc_i && req_i[i]) rdata_o[B_PEND] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/loc_own_arb.sv
module loc_own_arb
  import loc_own_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              exec_busy_i,
  input  logic              cmd_done_i,
  input  logic              cmd_abort_i,
  output logic              cancel_o,
  output logic              loc_changed_o,
  output logic              ready_o,
  output logic [LOC_W-1:0]  ready_loc_o,
  output logic [LOC_W-1:0]  owner_o,
  output logic              owner_valid_o
);
  localparam logic [LOC_W-1:0] NO_LOC = '1;
  localparam logic [LOC_W-1:0] RO_LOC = LOC_W'(NUM_LOC - 1);

  logic [LOC_W-1:0]   owner_q, abort_q, next_q, rloc_q;
  logic [NUM_LOC-1:0] req_q, seize_q, seized_q;
  logic               pend_q, chg_q, cancel_q, rdy_q;

  // stage A: completion of a deferred handover
  logic [LOC_W-1:0]   own_a, ab_a, nx_a, rloc_a;
  logic [NUM_LOC-1:0] req_a, sz_a, sd_a;
  logic               pend_a, chg_a, rdy_a;
  // stage B: engine abort and register write
  logic [LOC_W-1:0]   own_b, ab_b, nx_b, rloc_b;
  logic [NUM_LOC-1:0] req_b, sz_b, sd_b;
  logic               pend_b, chg_b, rdy_b, can_b;

  logic               pick_found;
  logic [LOC_W-1:0]   pick_idx;
  logic [LOC_W-1:0]   wloc;
  assign wloc = acc_addr_i[LOC_LSB +: LOC_W];

  function automatic void hand_over(
    input  logic [LOC_W-1:0]   n,
    inout  logic [LOC_W-1:0]   own,
    inout  logic [NUM_LOC-1:0] rq,
    inout  logic [NUM_LOC-1:0] sz,
    inout  logic [NUM_LOC-1:0] sd,
    inout  logic               chg
  );
    if (own != n) begin
      chg = 1'b1;
      if (own != NO_LOC) begin
        if (n != NO_LOC && sz[n]) sd[own] = 1'b1;
        else                      rq[own] = 1'b0;
      end
    end
    own = n;
    if (n != NO_LOC) begin
      rq[n] = 1'b0;
      sz[n] = 1'b0;
    end
  endfunction

  function automatic void do_abort(
    input  logic [LOC_W-1:0]   ab,
    input  logic [LOC_W-1:0]   nx,
    inout  logic [LOC_W-1:0]   own,
    inout  logic [NUM_LOC-1:0] rq,
    inout  logic [NUM_LOC-1:0] sz,
    inout  logic [NUM_LOC-1:0] sd,
    inout  logic               chg,
    inout  logic               rdy,
    inout  logic [LOC_W-1:0]   rloc
  );
    if (ab == nx) begin
      rdy  = 1'b1;
      rloc = ab;
    end
    hand_over(nx, own, rq, sz, sd, chg);
  endfunction

  always_comb begin
    own_a = owner_q; req_a = req_q; sz_a = seize_q; sd_a = seized_q;
    pend_a = pend_q; ab_a = abort_q; nx_a = next_q;
    chg_a = 1'b0; rdy_a = 1'b0; rloc_a = rloc_q;
    if (cmd_done_i && pend_q) begin
      do_abort(abort_q, next_q, own_a, req_a, sz_a, sd_a, chg_a, rdy_a, rloc_a);
      pend_a = 1'b0;
      ab_a   = NO_LOC;
      nx_a   = NO_LOC;
    end
  end

  lcl_prio_pick #(.N(NUM_LOC), .W(LOC_W)) u_pick (
    .vec_i  (req_a),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  always_comb begin
    logic [DATA_W-1:0] v;
    logic [LOC_W-1:0]  new_own;
    logic              set_new, hi, tgt_valid, do_prep;
    logic [LOC_W-1:0]  p_ab, p_nx;
    own_b = own_a; req_b = req_a; sz_b = sz_a; sd_b = sd_a;
    pend_b = pend_a; ab_b = ab_a; nx_b = nx_a;
    chg_b = chg_a; rdy_b = rdy_a; rloc_b = rloc_a; can_b = 1'b0;
    v = acc_wdata_i; new_own = own_a; set_new = 1'b0; hi = 1'b0;
    tgt_valid = 1'b0; do_prep = 1'b0; p_ab = NO_LOC; p_nx = NO_LOC;

    if (cmd_abort_i && own_b != NO_LOC) begin
      if (exec_busy_i) begin
        pend_b = 1'b1; ab_b = own_b; nx_b = own_b; can_b = 1'b1;
      end else begin
        do_abort(own_b, own_b, own_b, req_b, sz_b, sd_b, chg_b, rdy_b, rloc_b);
      end
    end

    if (acc_valid_i && acc_write_i && wloc < RO_LOC) begin
      tgt_valid = 1'b1;
      set_new   = 1'b1;
      new_own   = own_b;
      if (v[B_SEIZE]) begin
        v[B_REQ] = 1'b0;
        v[B_ACT] = 1'b0;
      end
      if (v[B_ACT]) begin
        if (own_b == wloc) begin
          if (pick_found) begin
            set_new = 1'b0; do_prep = 1'b1; p_ab = wloc; p_nx = pick_idx;
          end else begin
            new_own = NO_LOC;
          end
        end else begin
          req_b[wloc] = 1'b0;
        end
      end
      if (v[B_SEIZED]) sd_b[wloc] = 1'b0;
      if (v[B_SEIZE]) begin
        for (int i = 0; i < NUM_LOC; i++)
          if (LOC_W'(i) > wloc && sz_b[i]) hi = 1'b1;
        if ((own_b == NO_LOC || wloc > own_b) && !sz_b[wloc] && !hi) begin
          for (int i = 0; i < NUM_LOC; i++)
            if (LOC_W'(i) < wloc) sz_b[i] = 1'b0;
          sz_b[wloc] = 1'b1;
          set_new = 1'b0; do_prep = 1'b1; p_ab = own_b; p_nx = wloc;
        end
      end
      if (v[B_REQ] && own_b != wloc) begin
        if (own_b != NO_LOC) req_b[wloc] = 1'b1;
        else                 new_own = wloc;
      end
    end

    if (do_prep) begin
      if (exec_busy_i) begin
        pend_b = 1'b1; ab_b = p_ab; nx_b = p_nx; can_b = 1'b1;
      end else begin
        do_abort(p_ab, p_nx, own_b, req_b, sz_b, sd_b, chg_b, rdy_b, rloc_b);
        pend_b = 1'b0; ab_b = NO_LOC; nx_b = NO_LOC;
      end
    end else if (tgt_valid && set_new) begin
      hand_over(new_own, own_b, req_b, sz_b, sd_b, chg_b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= NO_LOC;
      abort_q  <= NO_LOC;
      next_q   <= NO_LOC;
      rloc_q   <= '0;
      req_q    <= '0;
      seize_q  <= '0;
      seized_q <= '0;
      pend_q   <= 1'b0;
      chg_q    <= 1'b0;
      cancel_q <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      owner_q  <= own_b;
      abort_q  <= ab_b;
      next_q   <= nx_b;
      rloc_q   <= rloc_b;
      req_q    <= req_b;
      seize_q  <= sz_b;
      seized_q <= sd_b;
      pend_q   <= pend_b;
      chg_q    <= chg_b;
      cancel_q <= can_b;
      rdy_q    <= rdy_b;
    end
  end

  lcl_read_view #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .DATA_W(DATA_W)) u_view (
    .loc_i   (wloc),
    .owner_i (owner_q),
    .req_i   (req_q),
    .seized_i(seized_q),
    .rdata_o (acc_rdata_o)
  );

  assign owner_o       = owner_q;
  assign owner_valid_o = (owner_q != NO_LOC);
  assign loc_changed_o = chg_q;
  assign cancel_o      = cancel_q;
  assign ready_o       = rdy_q;
  assign ready_loc_o   = rloc_q;
endmodule

// File: rtl/loc_own_arb_chk.sv
module loc_own_arb_chk
  import loc_own_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned DATA_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [DATA_W-1:0] acc_rdata_o,
  input logic              exec_busy_i,
  input logic              cmd_done_i,
  input logic              cmd_abort_i,
  input logic              cancel_o,
  input logic              loc_changed_o,
  input logic [LOC_W-1:0]  owner_o,
  input logic              owner_valid_o
);
  logic [LOC_W-1:0] loc;
  assign loc = acc_addr_i[LOC_LSB +: LOC_W];

  AST_CHG_MATCHES_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_changed_o == (owner_o != $past(owner_o))); // R10

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && loc == LOC_W'(NUM_LOC - 1) && !cmd_done_i && !cmd_abort_i)
    |=> $stable(owner_o)); // R2

  AST_CANCEL_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(exec_busy_i)); // R11

  AST_OWNER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_valid_o |-> (owner_o < LOC_W'(NUM_LOC))); // R5

  AST_ACTIVE_ONLY_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdata_o[B_ACT] |-> (owner_valid_o && owner_o == loc)); // R8

  AST_QUIET_HOLDS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !cmd_done_i && !cmd_abort_i) |=> $stable(owner_o)); // R11
endmodule

bind loc_own_arb loc_own_arb_chk #(
  .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .acc_addr_i   (acc_addr_i),
  .acc_rdata_o  (acc_rdata_o),
  .exec_busy_i  (exec_busy_i),
  .cmd_done_i   (cmd_done_i),
  .cmd_abort_i  (cmd_abort_i),
  .cancel_o     (cancel_o),
  .loc_changed_o(loc_changed_o),
  .owner_o      (owner_o),
  .owner_valid_o(owner_valid_o)
);

// File: tb/loc_own_arb_tb.sv
module loc_own_arb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        busy = 1'b0, done = 1'b0, abrt = 1'b0;
  logic        cancel, chg, rdy, own_v;
  logic [2:0]  rdy_loc, owner;

  int n_chk = 0, n_fail = 0;
  logic chg_s, can_s, rdy_s;
  logic [7:0] r;

  always #(CLK_PERIOD / 2) clk = ~clk;

  loc_own_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .exec_busy_i(busy), .cmd_done_i(done), .cmd_abort_i(abrt),
    .cancel_o(cancel), .loc_changed_o(chg), .ready_o(rdy), .ready_loc_o(rdy_loc),
    .owner_o(owner), .owner_valid_o(own_v)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; busy = 1'b0; done = 1'b0; abrt = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic capture();
    chg_s = chg; can_s = cancel; rdy_s = rdy;
  endtask

  task automatic wr(input int loc, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'(loc << 12); acc_wdata = d;
    @(negedge clk);
    capture();
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input int loc, output logic [7:0] val);
    acc_addr = 16'(loc << 12);
    #1;
    val = acc_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); capture(); done = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abrt = 1'b1;
    @(negedge clk); capture(); abrt = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R1 owner_valid after reset", own_v, 0);
    for (int i = 0; i < 5; i++) begin
      rd(i, r); chk_eq("R1 reset read", r, 8'h80);
    end
    rd(6, r); chk_eq("R2 loc6 reads zero", r, 8'h00);
  endtask

  task automatic t_request();
    wr(1, 8'h02);
    chk_eq("R3 idle request owns", {own_v, owner}, {1'b1, 3'd1});
    chk_eq("R10 change pulse", chg_s, 1);
    rd(1, r); chk_eq("R8 owner view", r, 8'hA0);
    wr(3, 8'h02);
    chk_eq("R3 busy request keeps owner", owner, 1);
    chk_eq("R10 no change pulse", chg_s, 0);
    rd(1, r); chk_eq("R8 pending seen by owner", r, 8'hA4);
    rd(3, r); chk_eq("R3 request flag", r, 8'h82);
    wr(0, 8'h02);
    rd(3, r); chk_eq("R8 pending from loc0", r, 8'h86);
  endtask

  task automatic t_nonowner_act();
    wr(0, 8'h20);
    chk_eq("R4 owner unchanged", owner, 1);
    rd(0, r); chk_eq("R4 request cleared", r, 8'h84);
  endtask

  task automatic t_release();
    wr(1, 8'h20);
    chk_eq("R5 highest requester owns", owner, 3);
    chk_eq("R10 pulse on release", chg_s, 1);
    rd(1, r); chk_eq("R7 old owner normal", r, 8'h80);
    rd(3, r); chk_eq("R8 new owner view", r, 8'hA0);
  endtask

  task automatic t_ro_loc();
    wr(4, 8'h02);
    chk_eq("R2 loc4 request ignored", owner, 3);
    rd(4, r); chk_eq("R2 loc4 flags untouched", r, 8'h80);
    wr(4, 8'h08);
    chk_eq("R2 loc4 seize ignored", owner, 3);
    wr(5, 8'h02);
    chk_eq("R2 loc5 write ignored", owner, 3);
  endtask

  task automatic t_seize_refused();
    wr(2, 8'h08);
    chk_eq("R6 lower seize refused", owner, 3);
    wr(0, 8'h0A);
    rd(0, r); chk_eq("R6 request bit with seize ignored", r, 8'h80);
    rd(3, r); chk_eq("R6 no pending after", r, 8'hA0);
  endtask

  task automatic t_release_none();
    wr(3, 8'h20);
    chk_eq("R5 no requester no owner", own_v, 0);
    chk_eq("R10 pulse to none", chg_s, 1);
  endtask

  task automatic t_seize();
    do_reset();
    wr(1, 8'h02);
    wr(2, 8'h02);
    wr(3, 8'h08);
    chk_eq("R6 higher seize owns", owner, 3);
    chk_eq("R10 pulse on seize", chg_s, 1);
    rd(1, r); chk_eq("R7 been-seized mark", r, 8'h94);
    rd(3, r); chk_eq("R8 seize bit hidden", r, 8'hA4);
    wr(1, 8'h10);
    rd(1, r); chk_eq("R9 been-seized cleared", r, 8'h84);
    wr(3, 8'h20);
    chk_eq("R5 release after seize", owner, 2);
    rd(3, r); chk_eq("R7 normal handover", r, 8'h80);
  endtask

  task automatic t_defer();
    do_reset();
    busy = 1'b1;
    wr(0, 8'h02);
    chk_eq("R3 idle grab while busy", owner, 0);
    chk_eq("R11 no cancel on idle grab", can_s, 0);
    wr(1, 8'h02);
    wr(0, 8'h20);
    chk_eq("R11 cancel requested", can_s, 1);
    chk_eq("R11 owner held", owner, 0);
    @(negedge clk);
    chk_eq("R11 owner still held", owner, 0);
    pulse_done();
    chk_eq("R11 handover on done", owner, 1);
    chk_eq("R10 pulse on done", chg_s, 1);
  endtask

  task automatic t_self_abort();
    busy = 1'b0;
    pulse_abort();
    chk_eq("R12 ready pulse", rdy_s, 1);
    chk_eq("R12 ready locality", rdy_loc, 1);
    chk_eq("R12 no owner change", chg_s, 0);
    busy = 1'b1;
    pulse_abort();
    chk_eq("R12 busy abort cancels", can_s, 1);
    chk_eq("R12 no ready yet", rdy_s, 0);
    pulse_done();
    chk_eq("R12 ready after done", rdy_s, 1);
    chk_eq("R12 owner kept", owner, 1);
  endtask

  task automatic t_seize_chain();
    do_reset();
    busy = 1'b1;
    wr(0, 8'h02);
    wr(1, 8'h08);
    chk_eq("R6 seize deferred cancel", can_s, 1);
    wr(2, 8'h08);
    chk_eq("R6 higher seize overrides", can_s, 1);
    wr(1, 8'h08);
    chk_eq("R6 seize below pending refused", can_s, 0);
    chk_eq("R11 owner held in chain", owner, 0);
    pulse_done();
    chk_eq("R6 highest seizer owns", owner, 2);
    rd(0, r); chk_eq("R7 seized owner mark", r, 8'h90);
    rd(1, r); chk_eq("R6 lower seize cancelled", r, 8'h80);
  endtask

  task automatic t_seize_idle();
    do_reset();
    wr(2, 8'h08);
    chk_eq("R6 seize with no owner", {own_v, owner}, {1'b1, 3'd2});
    chk_eq("R10 pulse seize idle", chg_s, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_request();
    t_nonowner_act();
    t_release();
    t_ro_loc();
    t_seize_refused();
    t_release_none();
    t_seize();
    t_defer();
    t_self_abort();
    t_seize_chain();
    t_seize_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule